// File: doc/BRIEF.md
# FIFO Flag Margin Register Loader

This block holds the two threshold margins that a FIFO's programmable flag logic compares against: one margin counted from the empty boundary and one counted from the full boundary. The FIFO storage and the comparators themselves sit outside. The block only keeps the two margins, loads them, reads them back, and keeps FIFO memory accesses away while the margins are being accessed.

A single configuration-select input is sampled during a hard reset. It sets the default value for both margins and also fixes how the margins can be reprogrammed later. In parallel mode the data bus writes whole margins. In serial mode one bit is shifted in per enabled clock. In either mode the margins can be read back over the output bus. A soft reset rewinds the access sequence. It leaves the margins and the loading mode alone.

Top module: `flag_margin_loader`

## Requirements
- R1: A hard reset (`hard_rst_n` low at a clock edge) with `cfg_sel` low loads 127 into both margins and selects parallel loading (`shift_mode` = 0).
- R2: A hard reset with `cfg_sel` high loads 1023 into both margins and selects serial loading (`shift_mode` = 1).
- R3: In parallel mode, each clock with `cfg_sel` and `wr_req` both high writes `din[OFF_W-1:0]` into exactly one margin. Successive accesses alternate empty, full, empty, and so on, and the sequence starts with the empty margin.
- R4: In serial mode, each clock with `cfg_sel` and `shift_en` both high stores `shift_bit` into the next bit. Bits fill the empty margin from bit 0 up to bit OFF_W-1, then the full margin the same way. After 2*OFF_W bits the position returns to bit 0 of the empty margin.
- R5: In serial mode, a parallel write (`cfg_sel`+`wr_req`) changes no margin. In parallel mode, a shift strobe (`cfg_sel`+`shift_en`) changes no margin.
- R6: In either mode, a clock with `cfg_sel` and `rd_req` both high places the next margin in the sequence, zero-extended, on `dout` and raises `dout_valid` for exactly the following cycle. Reads share the alternating pointer with parallel writes.
- R7: A soft reset (`soft_rst_n` low) keeps both margins and the loading mode. It returns the access pointer to the empty margin and the serial bit position to bit 0 of the empty margin.
- R8: `mem_wr_en` equals `wr_req` and `mem_rd_en` equals `rd_req` while `cfg_sel` is low. Both are low while `cfg_sel` is high.
- R9: In parallel mode, a clock with `cfg_sel`, `wr_req` and `rd_req` all high performs the write only. No readback follows, and the pointer advances once.
- R10: Strobes given while `cfg_sel` is low change no margin and raise no `dout_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Synchronous active-low hard reset; samples `cfg_sel` |
| soft_rst_n | input | 1 | Synchronous active-low soft reset; rewinds sequencing only |
| cfg_sel | input | 1 | Reset-time configuration select; afterwards routes strobes to the margins |
| shift_en | input | 1 | Serial bit strobe |
| shift_bit | input | 1 | Serial data bit |
| wr_req | input | 1 | Write strobe |
| rd_req | input | 1 | Read strobe |
| din | input | DATA_W | Parallel write data |
| dout | output | DATA_W | Readback data, registered |
| dout_valid | output | 1 | High for one cycle after a readback access |
| empty_margin | output | OFF_W | Margin from the empty boundary |
| full_margin | output | OFF_W | Margin from the full boundary |
| shift_mode | output | 1 | 1 = serial loading selected, 0 = parallel |
| mem_wr_en | output | 1 | Write enable passed on to FIFO storage |
| mem_rd_en | output | 1 | Read enable passed on to FIFO storage |

## Verification
Parallel loading is driven with a long run of arithmetically spread values written in alternating pairs. These show whether the pointer picks the correct margin and whether any bit of the data path is stuck or swapped. Serial loading is swept with a walking one across all 2*OFF_W bit positions, followed by dense mixed patterns. The walking one exposes a misplaced index or a reversed bit order, and the dense patterns catch stale bits. Cross-mode strobes, strobes without `cfg_sel`, a simultaneous write and read, and a soft reset in the middle of a sequence then separate a correct mode gate and pointer rewind from designs that merely store data.

// File: rtl/fml_pkg.sv
// Shared types for the flag margin loader.
// Assumes: exactly two margins, the empty one ordered first.
package fml_pkg;
    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } margin_sel_e;
endpackage

// File: rtl/fml_mode_latch.sv
// Loading-mode latch: captures the configuration select while hard reset is
// applied and holds it until the next hard reset. Soft reset has no effect.
// Assumes: the select is stable around the reset edge.
module fml_mode_latch (
    input  logic clk,
    input  logic hard_rst_n,
    input  logic cfg_sel,
    output logic shift_mode
);
    // Purpose: remember serial (1) or parallel (0) loading.
    always_ff @(posedge clk) begin
        if (!hard_rst_n) shift_mode <= cfg_sel;
    end
endmodule

// File: rtl/fml_access_seq.sv
// Parallel access sequencer: decodes writes and reads aimed at the margins
// and keeps the alternating empty/full pointer. A write wins over a read in
// the same cycle. Writes are refused in serial mode; reads work in both.
// Assumes: either reset returns the pointer to the empty margin.
module fml_access_seq
    import fml_pkg::*;
(
    input  logic        clk,
    input  logic        hard_rst_n,
    input  logic        soft_rst_n,
    input  logic        cfg_sel,
    input  logic        wr_req,
    input  logic        rd_req,
    input  logic        shift_mode,
    output logic [1:0]  par_we,
    output logic        rd_fire,
    output margin_sel_e rd_target
);
    margin_sel_e ptr_q;
    logic        wr_hit;
    logic        rd_hit;

    // Purpose: qualify the strobes against the select and the mode.
    always_comb begin
        wr_hit = cfg_sel && wr_req && !shift_mode;
        rd_hit = cfg_sel && rd_req && !wr_hit;
    end

    // Purpose: one-hot write enable for the margin under the pointer.
    always_comb begin
        par_we = 2'b00;
        if (wr_hit) par_we[ptr_q] = 1'b1;
        rd_fire   = rd_hit;
        rd_target = ptr_q;
    end

    // Purpose: advance the pointer once per accepted access.
    always_ff @(posedge clk) begin
        if (!hard_rst_n || !soft_rst_n) ptr_q <= SEL_EMPTY;
        else if (wr_hit || rd_hit)      ptr_q <= (ptr_q == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end
endmodule

// File: rtl/fml_shift_ctl.sv
// Serial shift controller: counts strobed bits across both margins, LSB
// first, the empty margin before the full one, wrapping after 2*OFF_W.
// Assumes: OFF_W >= 2; strobes are ignored in parallel mode.
module fml_shift_ctl #(
    parameter int OFF_W = 13
) (
    input  logic                     clk,
    input  logic                     hard_rst_n,
    input  logic                     soft_rst_n,
    input  logic                     cfg_sel,
    input  logic                     shift_en,
    input  logic                     shift_mode,
    output logic [1:0]               ser_we,
    output logic [$clog2(OFF_W)-1:0] ser_idx
);
    localparam int CNT_W = $clog2(2 * OFF_W);
    localparam int IDX_W = $clog2(OFF_W);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(2 * OFF_W - 1);
    localparam logic [CNT_W-1:0] SPLIT = CNT_W'(OFF_W);

    logic [CNT_W-1:0] cnt_q;
    logic             strobe;
    logic             upper;

    // Purpose: decode target margin and bit index from the count.
    always_comb begin
        strobe  = cfg_sel && shift_en && shift_mode;
        upper   = (cnt_q >= SPLIT);
        ser_idx = upper ? IDX_W'(cnt_q - SPLIT) : IDX_W'(cnt_q);
        ser_we  = 2'b00;
        if (strobe) ser_we[upper] = 1'b1;
    end

    // Purpose: step the bit position, wrapping at the end of the full margin.
    always_ff @(posedge clk) begin
        if (!hard_rst_n || !soft_rst_n) cnt_q <= '0;
        else if (strobe)                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/fml_margin_regs.sv
// Margin storage: two registers loaded with a default at hard reset, then
// written whole by the parallel path or bit by bit by the serial path.
// Assumes: the two write paths are never active in the same cycle.
module fml_margin_regs #(
    parameter int OFF_W      = 13,
    parameter int DFLT_SMALL = 127,
    parameter int DFLT_LARGE = 1023
) (
    input  logic                     clk,
    input  logic                     hard_rst_n,
    input  logic                     cfg_sel,
    input  logic [1:0]               par_we,
    input  logic [OFF_W-1:0]         par_data,
    input  logic [1:0]               ser_we,
    input  logic [$clog2(OFF_W)-1:0] ser_idx,
    input  logic                     shift_bit,
    output logic [1:0][OFF_W-1:0]    margin
);
    localparam logic [OFF_W-1:0] V_SMALL = OFF_W'(DFLT_SMALL);
    localparam logic [OFF_W-1:0] V_LARGE = OFF_W'(DFLT_LARGE);

    for (genvar g = 0; g < 2; g++) begin : g_margin
        logic [OFF_W-1:0] q;

        // Purpose: default at hard reset, then parallel or single-bit update.
        always_ff @(posedge clk) begin
            if (!hard_rst_n)    q <= cfg_sel ? V_LARGE : V_SMALL;
            else if (par_we[g]) q <= par_data;
            else if (ser_we[g]) q[ser_idx] <= shift_bit;
        end

        assign margin[g] = q;
    end
endmodule

// File: rtl/flag_margin_loader.sv
// Top level of the flag margin loader. Ties the mode latch, access
// sequencer, shift controller and storage together, registers readback
// data and keeps FIFO memory strobes off while margins are selected.
// Assumes: DATA_W >= OFF_W; all resets are synchronous and active low.
module flag_margin_loader
    import fml_pkg::*;
#(
    parameter int DATA_W     = 18,
    parameter int OFF_W      = 13,
    parameter int DFLT_SMALL = 127,
    parameter int DFLT_LARGE = 1023
) (
    input  logic              clk,
    input  logic              hard_rst_n,
    input  logic              soft_rst_n,
    input  logic              cfg_sel,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic [OFF_W-1:0]  empty_margin,
    output logic [OFF_W-1:0]  full_margin,
    output logic              shift_mode,
    output logic              mem_wr_en,
    output logic              mem_rd_en
);
    localparam int IDX_W = $clog2(OFF_W);

    logic [1:0]             par_we;
    logic [1:0]             ser_we;
    logic [IDX_W-1:0]       ser_idx;
    logic                   rd_fire;
    margin_sel_e            rd_target;
    logic [1:0][OFF_W-1:0]  margin;

    fml_mode_latch u_mode (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .cfg_sel    (cfg_sel),
        .shift_mode (shift_mode)
    );

    fml_access_seq u_seq (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .soft_rst_n (soft_rst_n),
        .cfg_sel    (cfg_sel),
        .wr_req     (wr_req),
        .rd_req     (rd_req),
        .shift_mode (shift_mode),
        .par_we     (par_we),
        .rd_fire    (rd_fire),
        .rd_target  (rd_target)
    );

    fml_shift_ctl #(.OFF_W(OFF_W)) u_shift (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .soft_rst_n (soft_rst_n),
        .cfg_sel    (cfg_sel),
        .shift_en   (shift_en),
        .shift_mode (shift_mode),
        .ser_we     (ser_we),
        .ser_idx    (ser_idx)
    );

    fml_margin_regs #(
        .OFF_W      (OFF_W),
        .DFLT_SMALL (DFLT_SMALL),
        .DFLT_LARGE (DFLT_LARGE)
    ) u_regs (
        .clk        (clk),
        .hard_rst_n (hard_rst_n),
        .cfg_sel    (cfg_sel),
        .par_we     (par_we),
        .par_data   (din[OFF_W-1:0]),
        .ser_we     (ser_we),
        .ser_idx    (ser_idx),
        .shift_bit  (shift_bit),
        .margin     (margin)
    );

    // Purpose: expose the stored margins to the flag comparators.
    always_comb begin
        empty_margin = margin[SEL_EMPTY];
        full_margin  = margin[SEL_FULL];
    end

    // Purpose: FIFO memory sees strobes only while margins are not selected.
    always_comb begin
        mem_wr_en = wr_req && !cfg_sel;
        mem_rd_en = rd_req && !cfg_sel;
    end

    // Purpose: register the readback word and its one-cycle valid.
    always_ff @(posedge clk) begin
        if (!hard_rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else if (!soft_rst_n) begin
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= rd_fire;
            if (rd_fire) dout <= DATA_W'(margin[rd_target]);
        end
    end
endmodule

// File: rtl/fml_checker.sv
// Property checker for the flag margin loader, bound to the top module.
// Observes ports only.
module fml_checker #(
    parameter int OFF_W      = 13,
    parameter int DFLT_SMALL = 127,
    parameter int DFLT_LARGE = 1023
) (
    input logic             clk,
    input logic             hard_rst_n,
    input logic             soft_rst_n,
    input logic             cfg_sel,
    input logic             shift_en,
    input logic             wr_req,
    input logic             rd_req,
    input logic [OFF_W-1:0] empty_margin,
    input logic [OFF_W-1:0] full_margin,
    input logic             shift_mode,
    input logic             dout_valid,
    input logic             mem_wr_en,
    input logic             mem_rd_en
);
    // R1: hard reset with select low gives small defaults and parallel mode.
    p_dflt_small_r1: assert property (@(posedge clk)
        (!hard_rst_n && !cfg_sel) |=>
        (empty_margin == OFF_W'(DFLT_SMALL) && full_margin == OFF_W'(DFLT_SMALL) && !shift_mode));

    // R2: hard reset with select high gives large defaults and serial mode.
    p_dflt_large_r2: assert property (@(posedge clk)
        (!hard_rst_n && cfg_sel) |=>
        (empty_margin == OFF_W'(DFLT_LARGE) && full_margin == OFF_W'(DFLT_LARGE) && shift_mode));

    // R3: a parallel write touches at most one margin.
    p_one_target_r3: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (!shift_mode && cfg_sel && wr_req && soft_rst_n) |=>
        ($stable(empty_margin) || $stable(full_margin)));

    // R5: in serial mode only shift strobes can alter the margins.
    p_serial_gate_r5: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (shift_mode && !(cfg_sel && shift_en)) |=>
        ($stable(empty_margin) && $stable(full_margin)));

    // R6: an accepted read is followed by a valid readback word.
    p_rd_valid_r6: assert property (@(posedge clk) disable iff (!hard_rst_n)
        (cfg_sel && rd_req && soft_rst_n && !(wr_req && !shift_mode)) |=> dout_valid);

    // R6: no readback valid without a read access.
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !(cfg_sel && rd_req) |=> !dout_valid);

    // R7: soft reset keeps margins and mode.
    p_soft_keep_r7: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !soft_rst_n |=>
        ($stable(empty_margin) && $stable(full_margin) && $stable(shift_mode)));

    // R8: memory strobes are silent while margins are selected.
    p_mem_quiet_r8: assert property (@(posedge clk)
        cfg_sel |-> (!mem_wr_en && !mem_rd_en));

    // R10: without the select no margin changes.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!hard_rst_n)
        !cfg_sel |=> ($stable(empty_margin) && $stable(full_margin)));
endmodule

bind flag_margin_loader fml_checker #(
    .OFF_W      (OFF_W),
    .DFLT_SMALL (DFLT_SMALL),
    .DFLT_LARGE (DFLT_LARGE)
) u_fml_checker (
    .clk          (clk),
    .hard_rst_n   (hard_rst_n),
    .soft_rst_n   (soft_rst_n),
    .cfg_sel      (cfg_sel),
    .shift_en     (shift_en),
    .wr_req       (wr_req),
    .rd_req       (rd_req),
    .empty_margin (empty_margin),
    .full_margin  (full_margin),
    .shift_mode   (shift_mode),
    .dout_valid   (dout_valid),
    .mem_wr_en    (mem_wr_en),
    .mem_rd_en    (mem_rd_en)
);

// File: tb/sim_flag_margin_loader.sv
`timescale 1ns/1ps
module sim_flag_margin_loader;
    localparam int DW   = 12;
    localparam int OW   = 10;
    localparam int MASK = (1 << OW) - 1;

    logic          clk = 1'b0;
    logic          hard_rst_n = 1'b0;
    logic          soft_rst_n = 1'b1;
    logic          cfg_sel = 1'b0;
    logic          shift_en = 1'b0;
    logic          shift_bit = 1'b0;
    logic          wr_req = 1'b0;
    logic          rd_req = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_valid;
    logic [OW-1:0] empty_margin;
    logic [OW-1:0] full_margin;
    logic          shift_mode;
    logic          mem_wr_en;
    logic          mem_rd_en;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model of the block.
    int m_e, m_f, m_ptr, m_cnt, m_ser;

    always #2.5 clk = ~clk;

    flag_margin_loader #(.DATA_W(DW), .OFF_W(OW)) u0 (
        .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n),
        .cfg_sel(cfg_sel), .shift_en(shift_en), .shift_bit(shift_bit),
        .wr_req(wr_req), .rd_req(rd_req), .din(din), .dout(dout),
        .dout_valid(dout_valid), .empty_margin(empty_margin),
        .full_margin(full_margin), .shift_mode(shift_mode),
        .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic hard_reset(input logic sel);
        hard_rst_n = 1'b0; cfg_sel = sel;
        tick(); tick();
        hard_rst_n = 1'b1; cfg_sel = 1'b0;
        m_e = sel ? 1023 : 127; m_f = m_e; m_ptr = 0; m_cnt = 0; m_ser = sel;
    endtask

    task automatic soft_reset();
        soft_rst_n = 1'b0; tick(); soft_rst_n = 1'b1;
        m_ptr = 0; m_cnt = 0;
    endtask

    task automatic check_margins(input string tag);
        check({tag, " empty"}, int'(empty_margin), m_e);
        check({tag, " full"},  int'(full_margin),  m_f);
    endtask

    // Parallel write with model update (refused by the model in serial mode).
    task automatic par_write(input int v);
        cfg_sel = 1'b1; wr_req = 1'b1; din = DW'(v);
        tick();
        cfg_sel = 1'b0; wr_req = 1'b0;
        if (!m_ser) begin
            if (m_ptr == 0) m_e = v & MASK; else m_f = v & MASK;
            m_ptr ^= 1;
        end
    endtask

    task automatic shift_one(input int b);
        cfg_sel = 1'b1; shift_en = 1'b1; shift_bit = b[0];
        tick();
        cfg_sel = 1'b0; shift_en = 1'b0;
        if (m_ser) begin
            if (m_cnt < OW) m_e = (m_e & ~(1 << m_cnt)) | (b[0] << m_cnt);
            else            m_f = (m_f & ~(1 << (m_cnt - OW))) | (b[0] << (m_cnt - OW));
            m_cnt = (m_cnt == 2 * OW - 1) ? 0 : m_cnt + 1;
        end
    endtask

    task automatic read_check(input string tag);
        cfg_sel = 1'b1; rd_req = 1'b1;
        tick();
        cfg_sel = 1'b0; rd_req = 1'b0;
        check({tag, " valid"}, int'(dout_valid), 1);
        check({tag, " data"},  int'(dout), (m_ptr == 0) ? m_e : m_f);
        m_ptr ^= 1;
        tick();
        check({tag, " valid drop"}, int'(dout_valid), 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: defaults with select low.
        hard_reset(1'b0);
        check("R1 mode", int'(shift_mode), 0);
        check_margins("R1 default");
        check("R1 dout reset", int'(dout), 0);
        check("R1 valid reset", int'(dout_valid), 0);

        // R3: parallel sweep, alternating targets, readback every 8 pairs (R6).
        for (int k = 0; k < 64; k++) begin
            par_write((k * 173 + 29) & MASK);
            par_write((k * 611 + 402) & MASK);
            check_margins("R3 parallel");
            if (k % 8 == 0) begin
                read_check("R6 par read empty");
                read_check("R6 par read full");
            end
        end

        // R5: shift strobes in parallel mode change nothing.
        for (int k = 0; k < 4; k++) shift_one(1);
        check_margins("R5 shift ignored");

        // R9: simultaneous write and read in parallel mode.
        cfg_sel = 1'b1; wr_req = 1'b1; rd_req = 1'b1; din = DW'(333);
        tick();
        cfg_sel = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
        if (m_ptr == 0) m_e = 333; else m_f = 333;
        m_ptr ^= 1;
        check("R9 no readback", int'(dout_valid), 0);
        check_margins("R9 write done");
        par_write(555);
        check_margins("R9 pointer advanced once");

        // R7: soft reset mid-sequence in parallel mode.
        par_write(77);
        soft_reset();
        check("R7 mode kept", int'(shift_mode), 0);
        check_margins("R7 kept");
        par_write(901);
        check_margins("R7 pointer rewound");

        // R8/R10: strobes without select reach memory only.
        wr_req = 1'b1; rd_req = 1'b1; shift_en = 1'b1; din = DW'(12); #1;
        check("R8 mem wr pass", int'(mem_wr_en), 1);
        check("R8 mem rd pass", int'(mem_rd_en), 1);
        tick();
        check("R10 no valid", int'(dout_valid), 0);
        check_margins("R10 unchanged");
        cfg_sel = 1'b1; #1;
        check("R8 mem wr blocked", int'(mem_wr_en), 0);
        check("R8 mem rd blocked", int'(mem_rd_en), 0);
        tick();
        cfg_sel = 1'b0; wr_req = 1'b0; rd_req = 1'b0; shift_en = 1'b0;
        // the write above hit the model pointer; read gives way to it
        if (m_ptr == 0) m_e = 12; else m_f = 12;
        m_ptr ^= 1;
        check_margins("R9 write over read");

        // R2: defaults with select high, serial mode.
        hard_reset(1'b1);
        check("R2 mode", int'(shift_mode), 1);
        check_margins("R2 default");
        read_check("R6 serial read empty");
        read_check("R6 serial read full");

        // R4: walking one across all 2*OW positions, then dense patterns.
        for (int k = 0; k < 2 * OW; k++) begin
            for (int j = 0; j < 2 * OW; j++) shift_one((j == k) ? 1 : 0);
            check_margins("R4 walking one");
        end
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 2 * OW; j++) shift_one(((j * 7 + k * 3) % 5) > 1);
            check_margins("R4 pattern");
            read_check("R6 serial readback empty");
            read_check("R6 serial readback full");
        end

        // R5: parallel writes in serial mode change nothing.
        par_write(5);
        par_write(6);
        check_margins("R5 write ignored");

        // R7: soft reset mid-shift rewinds to bit 0 of the empty margin.
        shift_one(1); shift_one(0); shift_one(1);
        soft_reset();
        check("R7 serial mode kept", int'(shift_mode), 1);
        check_margins("R7 serial kept");
        for (int j = 0; j < OW + 3; j++) shift_one((j % 3) == 0);
        check_margins("R7 serial rewound");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule